// File: doc/BRIEF.md
# Fixed-Point to Floating-Point Vector Converter

This block takes a packed vector of fixed-point integers and turns every lane into an IEEE floating-point number of the same width. A lane is either 16 bits wide, which gives a half-precision result, or 32 bits wide, which gives a single-precision result. The caller chooses the lane size and whether the source lanes are two's-complement or unsigned. A 6-bit immediate sets the binary point. Each result equals the lane's integer value divided by two to the power of the fraction-bit count.

Every lane goes through the same steps. The block takes the sign and the magnitude, counts leading zeros to normalise, and builds the exponent from the position of the top set bit minus the runtime fraction count. It then rounds the mantissa to nearest, with ties going to even. A vector is 128 bits, or 64 bits when the wide-vector select is low. In the 64-bit case the upper half of the result is zero. The result is registered, so it appears one clock after the inputs.

Top module: `fx2fp_vec`

## Requirements
- R1: `dst_vec` is a register. It holds the conversion of the inputs present at the previous rising clock edge. A synchronous, active-high `rst` clears it to all zeros.
- R2: The fraction-bit count is 64 minus `fbits_code`, and each result equals the lane integer divided by 2 to that power. With `lane_wide`=1 the legal codes are 32 to 63 (1 to 32 fraction bits). With `lane_wide`=0 the legal codes are 48 to 63 (1 to 16 fraction bits). Any other code gives an all-zero `dst_vec`.
- R3: Lane i occupies bits [i*W +: W], where W is 16 when `lane_wide`=0 and 32 when `lane_wide`=1. A 128-bit vector therefore holds eight 16-bit lanes or four 32-bit lanes. When `vec_128`=0, only the lower 64 bits are converted and bits [127:64] of the result are zero.
- R4: With `is_signed`=1 a lane is read as two's complement; with `is_signed`=0 it is read as unsigned. The most negative signed value converts exactly. For example, 0x80000000 with 1 fraction bit gives 0xCE800000.
- R5: A zero lane gives positive zero (all bits clear).
- R6: Results are rounded to nearest. When the discarded bits are exactly one half, the mantissa is rounded to the even value. If rounding carries out of the mantissa, the mantissa becomes zero and the exponent goes up by one.
- R7: A half-precision result whose biased exponent after rounding is below 1 is flushed to zero. The flushed zero keeps the sign of the input. A biased exponent at or above the all-ones code gives infinity.
- R8: The result sign bit is set exactly when the lane is negative in signed mode. In unsigned mode the sign bit is always clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_vec | input | 128 | Packed fixed-point source lanes |
| lane_wide | input | 1 | 1: 32-bit lanes to single precision; 0: 16-bit lanes to half precision |
| is_signed | input | 1 | 1: two's-complement lanes; 0: unsigned lanes |
| fbits_code | input | 6 | Immediate; fraction bits = 64 - code |
| vec_128 | input | 1 | 1: full 128-bit vector; 0: lower 64 bits only |
| dst_vec | output | 128 | Registered floating-point result lanes |

## Verification
The assertions assume that the inputs are held steady across each rising edge. They also assume that `rst` is high for at least one edge before the first useful cycle, because every property compares this cycle's inputs with the next cycle's register. The sign and zero properties are gated on a legal code and on the lane lying inside the selected vector length. This lets the stimulus use illegal codes and 64-bit mode freely without tripping them. The random stimulus mostly draws legal codes for the chosen lane size and sometimes injects an illegal one on purpose. It also masks magnitudes at random so that the half-precision flush path is reached.

// File: rtl/fx2fp_pkg.sv
package fx2fp_pkg;

  typedef enum logic {
    LANE_HALF   = 1'b0,
    LANE_SINGLE = 1'b1
  } lane_sz_e;

  // Fraction-bit count from the 6-bit immediate: 64 - code, kept to 6 bits
  // because legal codes (32..63) map onto 1..32.
  function automatic logic [5:0] fbits_of(input logic [5:0] code);
    logic [6:0] full;
    full = 7'd64 - {1'b0, code};
    return full[5:0];
  endfunction

  // Legal immediates: code[5] set for any lane size; code[4] also needed
  // for half-precision lanes (at most 16 fraction bits).
  function automatic logic code_legal(input logic [5:0] code, input lane_sz_e sz);
    return code[5] && ((sz == LANE_SINGLE) || code[4]);
  endfunction

endpackage

// File: rtl/fx2fp_lzc.sv
module fx2fp_lzc #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] zeros
);
  // Ascending scan: the highest set bit is the last to assign.
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fx2fp_lane.sv
module fx2fp_lane #(
  parameter int W     = 16,
  parameter int MAN_W = 10,
  parameter int EXP_W = 5
) (
  input  logic [W-1:0] x,
  input  logic         sgn_mode,
  input  logic [5:0]   fbits,
  output logic [W-1:0] res
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam int XB   = W - 1 - MAN_W;   // bits below the kept mantissa
  localparam int CW   = $clog2(W + 1);

  logic             neg;
  logic [W-1:0]     mag;
  logic [CW-1:0]    lz;
  logic [W-1:0]     norm;
  logic [MAN_W-1:0] man;
  logic             rnd_bit;
  logic             stk_bit;
  logic             rup;
  logic [MAN_W:0]   sum;
  logic             carry;
  int               ebias;

  // The magnitude of the most negative value is 2^(W-1). It fits the W-bit
  // unsigned magnitude because it is never re-read as signed.
  assign neg = sgn_mode & x[W-1];
  assign mag = neg ? (~x + 1'b1) : x;

  fx2fp_lzc #(.W(W), .CW(CW)) u_lzc (
    .val   (mag),
    .zeros (lz)
  );

  assign norm    = mag << lz;
  assign man     = norm[W-2 -: MAN_W];
  assign rnd_bit = norm[XB-1];
  assign stk_bit = |norm[XB-2:0];
  assign rup     = rnd_bit & (stk_bit | man[0]);
  assign sum     = {1'b0, man} + {{MAN_W{1'b0}}, rup};
  assign carry   = sum[MAN_W];

  always_comb begin
    ebias = (W - 1 + BIAS) - int'(lz) - int'(fbits) + int'(carry);
    if (mag == '0) begin
      res = '0;
    end else if (ebias < 1) begin
      res = {neg, {(W-1){1'b0}}};
    end else if (ebias >= EMAX) begin
      res = {neg, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else begin
      res = {neg, EXP_W'(ebias), sum[MAN_W-1:0]};
    end
  end

  // The normalised magnitude always has its top bit set unless it is zero.
  always_comb begin
    a_r6_norm_lead: assert (mag == '0 || norm[W-1]);
  end

endmodule

// File: rtl/fx2fp_vec.sv
module fx2fp_vec
  import fx2fp_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int NW     = 16,
  parameter int N_MAN  = 10,
  parameter int N_EXP  = 5,
  parameter int WW     = 32,
  parameter int W_MAN  = 23,
  parameter int W_EXP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] src_vec,
  input  logic             lane_wide,
  input  logic             is_signed,
  input  logic [5:0]       fbits_code,
  input  logic             vec_128,
  output logic [VEC_W-1:0] dst_vec
);
  localparam int NLN  = VEC_W / NW;
  localparam int NLW  = VEC_W / WW;
  localparam int HALF = VEC_W / 2;

  lane_sz_e         sz;
  logic [5:0]       fb;
  logic             legal;
  logic [VEC_W-1:0] out_n;
  logic [VEC_W-1:0] out_w;
  logic [VEC_W-1:0] nxt;

  assign sz    = lane_wide ? LANE_SINGLE : LANE_HALF;
  assign fb    = fbits_of(fbits_code);
  assign legal = code_legal(fbits_code, sz);

  for (genvar g = 0; g < NLN; g++) begin : g_half
    fx2fp_lane #(.W(NW), .MAN_W(N_MAN), .EXP_W(N_EXP)) u_lane (
      .x        (src_vec[g*NW +: NW]),
      .sgn_mode (is_signed),
      .fbits    (fb),
      .res      (out_n[g*NW +: NW])
    );

    // R5 / R8 per half-precision lane inside the active vector
    a_r5_half_zero: assert property (@(posedge clk) disable iff (rst)
      (legal && !lane_wide && (vec_128 || g < NLN/2) && src_vec[g*NW +: NW] == '0)
      |=> dst_vec[g*NW +: NW] == '0);
    a_r8_half_sign: assert property (@(posedge clk) disable iff (rst)
      (legal && !lane_wide && (vec_128 || g < NLN/2) && src_vec[g*NW +: NW] != '0)
      |=> dst_vec[g*NW + NW - 1] == $past(is_signed & src_vec[g*NW + NW - 1]));
  end

  for (genvar g = 0; g < NLW; g++) begin : g_single
    fx2fp_lane #(.W(WW), .MAN_W(W_MAN), .EXP_W(W_EXP)) u_lane (
      .x        (src_vec[g*WW +: WW]),
      .sgn_mode (is_signed),
      .fbits    (fb),
      .res      (out_w[g*WW +: WW])
    );

    a_r5_single_zero: assert property (@(posedge clk) disable iff (rst)
      (legal && lane_wide && (vec_128 || g < NLW/2) && src_vec[g*WW +: WW] == '0)
      |=> dst_vec[g*WW +: WW] == '0);
    a_r8_single_sign: assert property (@(posedge clk) disable iff (rst)
      (legal && lane_wide && (vec_128 || g < NLW/2) && src_vec[g*WW +: WW] != '0)
      |=> dst_vec[g*WW + WW - 1] == $past(is_signed & src_vec[g*WW + WW - 1]));
  end

  always_comb begin
    nxt = '0;
    if (legal) nxt = (sz == LANE_SINGLE) ? out_w : out_n;
    if (!vec_128) nxt[VEC_W-1:HALF] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) dst_vec <= '0;
    else     dst_vec <= nxt;
  end

  a_r2_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    !legal |=> dst_vec == '0);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !vec_128 |=> dst_vec[VEC_W-1:HALF] == '0);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> dst_vec == '0);

endmodule

// File: tb/test_fx2fp_vec.sv
`timescale 1ns/1ps
module test_fx2fp_vec;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src_vec = '0;
  logic         lane_wide = 1'b0;
  logic         is_signed = 1'b0;
  logic [5:0]   fbits_code = 6'd63;
  logic         vec_128 = 1'b1;
  logic [127:0] dst_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fx2fp_vec i_fx2fp_vec (
    .clk(clk), .rst(rst), .src_vec(src_vec), .lane_wide(lane_wide),
    .is_signed(is_signed), .fbits_code(fbits_code), .vec_128(vec_128),
    .dst_vec(dst_vec)
  );

  // Reference: one lane, integer arithmetic on the exact value.
  function automatic logic [31:0] ref_lane(longint x, int w, bit sgn, int f);
    int man, bias, emax, p, e, be, sh;
    longint mag, q, rem, half;
    bit neg;
    man  = (w == 32) ? 23 : 10;
    bias = (w == 32) ? 127 : 15;
    emax = (w == 32) ? 255 : 31;
    neg  = sgn && (((x >> (w - 1)) & 64'd1) == 64'd1);
    mag  = neg ? ((64'd1 << w) - x) : x;
    if (mag == 0) return 32'd0;
    p = 0;
    for (int i = 0; i < w; i++) if (((mag >> i) & 64'd1) == 64'd1) p = i;
    e = p - f;
    if (p > man) begin
      sh   = p - man;
      q    = mag >> sh;
      rem  = mag & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
    end else begin
      q = mag << (man - p);
    end
    if (q == (64'd1 << (man + 1))) begin
      q = q >> 1;
      e = e + 1;
    end
    be = e + bias;
    if (be < 1) return 32'(longint'(neg) << (w - 1));
    if (be >= emax) return 32'((longint'(neg) << (w - 1)) | (longint'(emax) << man));
    return 32'((longint'(neg) << (w - 1)) | (longint'(be) << man) | (q & ((64'd1 << man) - 1)));
  endfunction

  function automatic logic [127:0] ref_vec(logic [127:0] v, bit wide, bit sgn,
                                           int code, bit v128);
    logic [127:0] r;
    int w, n, f;
    r = '0;
    w = wide ? 32 : 16;
    n = (v128 ? 128 : 64) / w;
    f = 64 - code;
    if (code < 32 || (!wide && code < 48)) return r;
    for (int i = 0; i < n; i++) begin
      if (wide) r[i*32 +: 32] = ref_lane(longint'(v[i*32 +: 32]), 32, sgn, f);
      else      r[i*16 +: 16] = ref_lane(longint'(v[i*16 +: 16]), 16, sgn, f)[15:0];
    end
    return r;
  endfunction

  task automatic run(logic [127:0] v, bit wide, bit sgn, int code, bit v128, string tag);
    logic [127:0] exp_v;
    @(negedge clk);
    src_vec = v; lane_wide = wide; is_signed = sgn;
    fbits_code = 6'(code); vec_128 = v128;
    exp_v = ref_vec(v, wide, sgn, code, v128);
    @(negedge clk);
    checks++;
    if (dst_vec !== exp_v) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, dst_vec, exp_v);
    end
  endtask

  initial begin
    repeat (5000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    bit wide, sgn, v128;
    int code;
    void'($urandom(32'd2024));
    src_vec = {4{32'hDEADBEEF}};
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (dst_vec !== '0) begin
      errors++;
      $display("FAIL R1 got %h exp %h", dst_vec, 128'd0);
    end
    rst = 1'b0;

    run('0, 1'b1, 1'b1, 40, 1'b1, "R5 zero single");
    run('0, 1'b0, 1'b1, 60, 1'b1, "R5 zero half");
    run({4{32'h80000000}}, 1'b1, 1'b1, 63, 1'b1, "R4 most negative single");
    run({4{32'h7FFFFFFF}}, 1'b1, 1'b1, 32, 1'b1, "R4 most positive single");
    run({8{16'h8000}}, 1'b0, 1'b1, 48, 1'b1, "R4 most negative half");
    run({4{32'h80000000}}, 1'b1, 1'b0, 63, 1'b1, "R8 unsigned top bit");
    run({32'h01000001, 32'h01000003, 32'h01000002, 32'hFFFFFFFF},
        1'b1, 1'b0, 62, 1'b1, "R6 single ties and carry");
    run({16'h0801, 16'h0803, 16'h0805, 16'hFFFF, 16'h0FFF, 16'h0802, 16'h0807, 16'h0001},
        1'b0, 1'b0, 56, 1'b1, "R6 half ties and carry");
    run({16'h0001, 16'hFFFF, 16'h0003, 16'h0002, 16'h0004, 16'hFFFC, 16'h0007, 16'h8001},
        1'b0, 1'b1, 48, 1'b1, "R7 half flush with sign");
    run({4{32'h12345678}}, 1'b1, 1'b1, 16, 1'b1, "R2 illegal code single");
    run({8{16'h1234}}, 1'b0, 1'b0, 40, 1'b1, "R2 illegal code half");
    run({4{32'h89ABCDEF}}, 1'b1, 1'b1, 50, 1'b0, "R3 64-bit single");
    run({8{16'hC0DE}}, 1'b0, 1'b0, 55, 1'b0, "R3 64-bit half");
    run({32'h00000001, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000},
        1'b1, 1'b1, 32, 1'b1, "R2 extremes 32 fraction bits");

    for (int k = 0; k < 400; k++) begin
      v    = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 3 == 0) v = v & {8{16'h00FF}};
      wide = 1'($urandom);
      sgn  = 1'($urandom);
      v128 = ($urandom % 4) != 0;
      code = wide ? 32 + int'($urandom % 32) : 48 + int'($urandom % 16);
      if ($urandom % 16 == 0) code = int'($urandom % 48);
      run(v, wide, sgn, code, v128, "R2 random");
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset mid-run
    if (dst_vec !== '0) begin
      errors++;
      $display("FAIL R1 got %h exp %h", dst_vec, 128'd0);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule